// File: doc/BRIEF.md
# Interface Activity Watchdog with Per-Channel Alarm Actions

This block supervises a host command interface. A protocol decoder upstream strobes one input for every well-formed command and a second input for a dedicated keep-alive command. A free-running prescaler supplies a tick. The block counts ticks since the last qualifying refresh. When the count reaches a programmable limit it declares an expiry: it raises an alarm flag and pulls an active-low, open-drain interrupt line low toward the host.

At expiry each output channel that is enabled for the alarm takes the response selected for it. A channel set to gate is forced off until the host acknowledges. A channel set to clear receives a one-cycle request to reload its default value. A channel set to hold freezes its last value for as long as the alarm lasts.

A two-bit safety level sets which commands count as a refresh and whether a refresh may also retire the alarm. At the strictest setting only an explicit status acknowledge can retire it. A limit of zero keeps the block dormant.

Top module: `iface_watchdog`

## Requirements
- R1: After reset, irq_oe_o, alarm_o and every bit of ch_gate_o, ch_clear_o and ch_hold_o are 0.
- R2: While cfg_timeout_i is 0, no expiry occurs however many ticks arrive.
- R3: With a limit T of at least 1, expiry happens at the clock edge that samples the T-th counted tick since the last restart. Its effects are visible on the outputs right after that edge.
- R4: cfg_level_i decides what counts as a refresh. Code 00 accepts cmd_valid_i or cmd_refresh_i. Codes 01, 10 and 11 accept only cmd_refresh_i. A refresh sets the tick count back to zero.
- R5: When a refresh and a tick are sampled in the same cycle, the refresh wins and the tick is not counted.
- R6: Channel i takes its action from ch_action_i[2i+1:2i]: 00 is gate, 01 is clear, and 10 or 11 is hold. A channel whose ch_alarm_en_i bit is 0 ignores expiry, and all three of its outputs stay 0.
- R7: For a clear channel, ch_clear_o is high for exactly the one cycle that follows the expiry edge.
- R8: For a gate channel, ch_gate_o rises at expiry. It stays high until a status_ack_i is sampled in a cycle without a new expiry.
- R9: For a hold channel, ch_hold_o rises at expiry and falls together with alarm_o.
- R10: alarm_o rises at expiry. At codes 00 and 01 it is released by a qualifying refresh or by status_ack_i. At codes 10 and 11 it is released only by status_ack_i.
- R11: irq_oe_o rises at expiry and falls only on status_ack_i. irq_data_o is always 0.
- R12: When an expiry and status_ack_i fall in the same cycle, the expiry wins and every flag it sets ends up high.
- R13: After an expiry the count restarts from zero, so the next expiry needs another T ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe for any well-formed host command |
| cmd_refresh_i | input | 1 | One-cycle strobe for the dedicated keep-alive command |
| status_ack_i | input | 1 | One-cycle strobe for the host status read/acknowledge |
| tick_i | input | 1 | Prescaled time-base tick |
| cfg_timeout_i | input | TIMEOUT_W (8) | Expiry limit in ticks; 0 disables |
| cfg_level_i | input | 2 | Safety level code |
| ch_alarm_en_i | input | NUM_CH (8) | Per-channel alarm enable |
| ch_action_i | input | 2*NUM_CH (16) | Per-channel action codes |
| ch_gate_o | output | NUM_CH (8) | Per-channel force-off request |
| ch_clear_o | output | NUM_CH (8) | Per-channel one-cycle reload-default request |
| ch_hold_o | output | NUM_CH (8) | Per-channel freeze request |
| alarm_o | output | 1 | Latched alarm flag |
| irq_oe_o | output | 1 | Interrupt pull-down enable |
| irq_data_o | output | 1 | Interrupt data value, constant 0 |

## Verification
An expiry and a status acknowledge can land on the same edge. One tries to set the alarm, interrupt and gate flags while the other tries to clear them. The bench provokes this in a directed case with a limit of 1, tick held high and the acknowledge pulsed at the same time, and expects every flag the expiry touches to read high afterwards. In the random phase, ticks and acknowledges overlap often, and every cycle is judged against the requirement-level model, which gives the expiry precedence.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      ACT_GATE     = 2'b00,
      ACT_CLEAR    = 2'b01,
      ACT_HOLD     = 2'b10,
      ACT_HOLD_ALT = 2'b11
   } ch_action_e;

   typedef enum logic [1:0] {
      LVL_ANY         = 2'b00,
      LVL_DEDICATED   = 2'b01,
      LVL_LATCHED     = 2'b10,
      LVL_LATCHED_ALT = 2'b11
   } safety_level_e;

   // Which strobes restart the count at a given level.
   function automatic logic refresh_qualifies(safety_level_e lvl, logic any_cmd, logic keepalive);
      logic q;
      unique case (lvl)
         LVL_ANY: q = any_cmd | keepalive;
         default: q = keepalive;
      endcase
      return q;
   endfunction

   // Whether a refresh may also retire a raised alarm.
   function automatic logic refresh_releases(safety_level_e lvl);
      return (lvl == LVL_ANY) || (lvl == LVL_DEDICATED);
   endfunction

endpackage

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] cnt_inc;
   logic             armed;

   assign armed   = (limit_i != '0);
   assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
   // ">=" also covers a limit lowered below the running count
   assign expire_o = armed && tick_i && !restart_i && (cnt_inc >= {1'b0, limit_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!armed || restart_i || expire_o)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_inc[CNT_W-1:0];
   end
endmodule

// File: rtl/wdog_alarm_ctrl.sv
module wdog_alarm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic ack_i,
   input  logic refresh_i,
   input  logic self_release_i,
   output logic alarm_o,
   output logic irq_pend_o,
   output logic release_o
);
   logic alarm_q, irq_q;

   // an expiry in the same cycle always outranks a release
   assign release_o = !expire_i && (ack_i || (self_release_i && refresh_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (expire_i)       alarm_q <= 1'b1;
         else if (release_o) alarm_q <= 1'b0;
         if (expire_i)       irq_q   <= 1'b1;
         else if (ack_i)     irq_q   <= 1'b0;
      end
   end

   assign alarm_o    = alarm_q;
   assign irq_pend_o = irq_q;
endmodule

// File: rtl/wdog_chan_action.sv
module wdog_chan_action
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       alarm_en_i,
   input  logic [1:0] action_i,
   input  logic       expire_i,
   input  logic       ack_i,
   input  logic       release_i,
   output logic       gate_o,
   output logic       clear_o,
   output logic       hold_o
);
   ch_action_e act;
   logic       hit, hit_gate, hit_clear, hit_hold;
   logic       gate_q, clear_q, hold_q;

   assign act       = ch_action_e'(action_i);
   assign hit       = expire_i && alarm_en_i;
   assign hit_gate  = hit && (act == ACT_GATE);
   assign hit_clear = hit && (act == ACT_CLEAR);
   assign hit_hold  = hit && ((act == ACT_HOLD) || (act == ACT_HOLD_ALT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q  <= 1'b0;
         clear_q <= 1'b0;
         hold_q  <= 1'b0;
      end else begin
         gate_q  <= hit_gate | (gate_q & ~(ack_i & ~expire_i));
         clear_q <= hit_clear;
         hold_q  <= hit_hold | (hold_q & ~release_i);
      end
   end

   assign gate_o  = gate_q;
   assign clear_o = clear_q;
   assign hold_o  = hold_q;
endmodule

// File: rtl/iface_watchdog.sv
module iface_watchdog
   import wdog_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int TIMEOUT_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid_i,
   input  logic                   cmd_refresh_i,
   input  logic                   status_ack_i,
   input  logic                   tick_i,
   input  logic [TIMEOUT_W-1:0]   cfg_timeout_i,
   input  logic [1:0]             cfg_level_i,
   input  logic [NUM_CH-1:0]      ch_alarm_en_i,
   input  logic [2*NUM_CH-1:0]    ch_action_i,
   output logic [NUM_CH-1:0]      ch_gate_o,
   output logic [NUM_CH-1:0]      ch_clear_o,
   output logic [NUM_CH-1:0]      ch_hold_o,
   output logic                   alarm_o,
   output logic                   irq_oe_o,
   output logic                   irq_data_o
);
   localparam int ACT_W = 2;

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_num_ch
      $error("iface_watchdog: NUM_CH must lie in 1..64");
   end
   if (TIMEOUT_W < 2 || TIMEOUT_W > 24) begin : g_bad_timeout_w
      $error("iface_watchdog: TIMEOUT_W must lie in 2..24");
   end

   safety_level_e level;
   logic          refresh_q, self_release, expire, release_ev, irq_pend;

   assign level        = safety_level_e'(cfg_level_i);
   assign refresh_q    = refresh_qualifies(level, cmd_valid_i, cmd_refresh_i);
   assign self_release = refresh_releases(level);

   wdog_tick_counter #(.CNT_W(TIMEOUT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .restart_i (refresh_q),
      .limit_i   (cfg_timeout_i),
      .expire_o  (expire)
   );

   wdog_alarm_ctrl u_alarm (
      .clk            (clk),
      .rst_n          (rst_n),
      .expire_i       (expire),
      .ack_i          (status_ack_i),
      .refresh_i      (refresh_q),
      .self_release_i (self_release),
      .alarm_o        (alarm_o),
      .irq_pend_o     (irq_pend),
      .release_o      (release_ev)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      wdog_chan_action u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .alarm_en_i (ch_alarm_en_i[g]),
         .action_i   (ch_action_i[ACT_W*g +: ACT_W]),
         .expire_i   (expire),
         .ack_i      (status_ack_i),
         .release_i  (release_ev),
         .gate_o     (ch_gate_o[g]),
         .clear_o    (ch_clear_o[g]),
         .hold_o     (ch_hold_o[g])
      );
   end

   // open-drain: enable pulls the line low, data is tied low
   assign irq_oe_o   = irq_pend;
   assign irq_data_o = 1'b0;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
   parameter int NUM_CH    = 8,
   parameter int TIMEOUT_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 status_ack_i,
   input logic [TIMEOUT_W-1:0] cfg_timeout_i,
   input logic [1:0]           cfg_level_i,
   input logic [NUM_CH-1:0]    ch_gate_o,
   input logic [NUM_CH-1:0]    ch_clear_o,
   input logic [NUM_CH-1:0]    ch_hold_o,
   input logic                 alarm_o,
   input logic                 irq_oe_o
);
   // R2
   dormant_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_timeout_i == '0) |=> !$rose(irq_oe_o));

   // R11
   irq_with_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_oe_o) |-> alarm_o);

   // R7
   clear_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_clear_o) |-> irq_oe_o);

   // R8
   gate_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(ch_gate_o) & ~ch_gate_o)) |-> $past(status_ack_i));

   // R9
   hold_needs_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_hold_o) |-> alarm_o);

   // R10
   latched_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level_i[1] && alarm_o && !status_ack_i) |=> alarm_o);
endmodule

bind iface_watchdog wdog_checker #(.NUM_CH(NUM_CH), .TIMEOUT_W(TIMEOUT_W)) u_wdog_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .status_ack_i  (status_ack_i),
   .cfg_timeout_i (cfg_timeout_i),
   .cfg_level_i   (cfg_level_i),
   .ch_gate_o     (ch_gate_o),
   .ch_clear_o    (ch_clear_o),
   .ch_hold_o     (ch_hold_o),
   .alarm_o       (alarm_o),
   .irq_oe_o      (irq_oe_o)
);

// File: tb/iface_watchdog_bench.sv
`timescale 1ns/100ps
module iface_watchdog_bench;
   localparam int NCH = 8;
   localparam int TW  = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid_i = 0, cmd_refresh_i = 0, status_ack_i = 0, tick_i = 0;
   logic [TW-1:0]   cfg_timeout_i = '0;
   logic [1:0]      cfg_level_i = '0;
   logic [NCH-1:0]  ch_alarm_en_i = '0;
   logic [2*NCH-1:0] ch_action_i = '0;
   logic [NCH-1:0]  ch_gate_o, ch_clear_o, ch_hold_o;
   logic            alarm_o, irq_oe_o, irq_data_o;

   int errors = 0;
   int checks = 0;

   // model state
   int             m_cnt;
   logic           m_alarm, m_irq;
   logic [NCH-1:0] m_gate, m_clear, m_hold;

   always #2.5 clk = ~clk;

   iface_watchdog #(.NUM_CH(NCH), .TIMEOUT_W(TW)) u_iface_watchdog (.*);

   task automatic check_val(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_alarm = 0; m_irq = 0; m_gate = '0; m_clear = '0; m_hold = '0;
   endtask

   // Expected behaviour, taken from the requirement list.
   task automatic model_step();
      logic ref_ok, exp_ev, rel;
      int   t;
      t      = int'(cfg_timeout_i);
      ref_ok = (cfg_level_i == 2'b00) ? (cmd_valid_i | cmd_refresh_i) : cmd_refresh_i;   // R4
      exp_ev = (t != 0) && tick_i && !ref_ok && (m_cnt + 1 >= t);                       // R2 R3 R5
      if (t == 0 || ref_ok || exp_ev) m_cnt = 0;                                         // R13
      else if (tick_i) m_cnt = m_cnt + 1;
      rel = !exp_ev && (status_ack_i || (cfg_level_i[1] == 1'b0 && ref_ok));             // R10 R12
      for (int i = 0; i < NCH; i++) begin
         logic [1:0] a;
         logic hit;
         a   = ch_action_i[2*i +: 2];
         hit = exp_ev && ch_alarm_en_i[i];                                               // R6
         m_gate[i]  = (hit && a == 2'b00) || (m_gate[i] && !(status_ack_i && !exp_ev));  // R8
         m_clear[i] = hit && a == 2'b01;                                                 // R7
         m_hold[i]  = (hit && a[1]) || (m_hold[i] && !rel);                              // R9
      end
      m_alarm = exp_ev || (m_alarm && !rel);
      m_irq   = exp_ev || (m_irq && !status_ack_i);                                      // R11
   endtask

   task automatic check_all(string req);
      check_val(req, "R8 gate",   64'(ch_gate_o),  64'(m_gate));
      check_val(req, "R7 clear",  64'(ch_clear_o), 64'(m_clear));
      check_val(req, "R9 hold",   64'(ch_hold_o),  64'(m_hold));
      check_val(req, "R10 alarm", 64'(alarm_o),    64'(m_alarm));
      check_val(req, "R11 irq",   64'(irq_oe_o),   64'(m_irq));
      check_val(req, "R11 data",  64'(irq_data_o), 64'(0));
   endtask

   // inputs set at negedge; one edge; compare at next negedge
   task automatic step(string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all(req);
   endtask

   task automatic idle();
      cmd_valid_i = 0; cmd_refresh_i = 0; status_ack_i = 0; tick_i = 0;
   endtask

   task automatic ack_all();
      idle(); status_ack_i = 1; step("R8");
      status_ack_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1f2e_3d4c));
      model_reset();
      // ch0 gate, ch1 clear, ch2 hold(10), ch3 hold(11), ch4 gate but disabled, ch5..7 clear/gate/hold
      ch_action_i   = {2'b10, 2'b00, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
      ch_alarm_en_i = 8'b1110_1111;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_val("R1", "irq", 64'(irq_oe_o), 0);
      check_val("R1", "alarm", 64'(alarm_o), 0);
      check_val("R1", "chan", 64'({ch_gate_o, ch_clear_o, ch_hold_o}), 0);

      // R2 dormant with a zero limit
      cfg_timeout_i = 0; tick_i = 1;
      repeat (300) step("R2");
      check_val("R2", "irq after 300 ticks", 64'(irq_oe_o), 0);

      // R3 exact expiry cycle, T=5
      cfg_timeout_i = 5; cfg_level_i = 2'b00;
      repeat (4) step("R3");
      check_val("R3", "irq before T", 64'(irq_oe_o), 0);
      step("R3");
      check_val("R3", "irq at T", 64'(irq_oe_o), 1);
      check_val("R7", "clear ch1", 64'(ch_clear_o[1]), 1);
      check_val("R6", "disabled ch4", 64'({ch_gate_o[4], ch_clear_o[4], ch_hold_o[4]}), 0);
      tick_i = 0; step("R7");
      check_val("R7", "clear one cycle", 64'(ch_clear_o[1]), 0);
      ack_all();
      check_val("R8", "gate ch0 released", 64'(ch_gate_o[0]), 0);
      check_val("R11", "irq released", 64'(irq_oe_o), 0);

      // R13 restart after expiry: 5 more ticks needed
      tick_i = 1;
      repeat (4) step("R13");
      check_val("R13", "no early re-expiry", 64'(irq_oe_o), 0);
      step("R13");
      check_val("R13", "re-expiry", 64'(irq_oe_o), 1);
      ack_all();

      // R4 level 1: cmd_valid does not refresh; level 0 it does
      cfg_level_i = 2'b01; tick_i = 1;
      for (int k = 0; k < 5; k++) begin cmd_valid_i = (k == 3); step("R4"); end
      check_val("R4", "level1 ignores cmd_valid", 64'(irq_oe_o), 1);
      ack_all();
      cfg_level_i = 2'b00; tick_i = 1;
      for (int k = 0; k < 5; k++) begin cmd_valid_i = (k == 3); step("R4"); end
      check_val("R4", "level0 cmd_valid refreshes", 64'(irq_oe_o), 0);
      cmd_valid_i = 0;

      // R5 refresh and tick together every cycle: never expires
      cmd_refresh_i = 1; tick_i = 1;
      repeat (12) step("R5");
      check_val("R5", "refresh beats tick", 64'(irq_oe_o), 0);
      idle();

      // R12 expiry and ack on the same edge, T=1
      cfg_timeout_i = 1; tick_i = 1; status_ack_i = 1;
      step("R12");
      check_val("R12", "irq set", 64'(irq_oe_o), 1);
      check_val("R12", "gate ch0 set", 64'(ch_gate_o[0]), 1);
      idle(); ack_all();

      // R10 level 2: refresh cannot release the alarm
      cfg_level_i = 2'b10; tick_i = 1; step("R10");
      tick_i = 0; cmd_refresh_i = 1; repeat (3) step("R10");
      check_val("R10", "latched alarm", 64'(alarm_o), 1);
      check_val("R9", "hold ch2", 64'(ch_hold_o[2]), 1);
      idle(); ack_all();
      check_val("R10", "ack releases", 64'(alarm_o), 0);
      check_val("R9", "hold follows alarm", 64'(ch_hold_o[2]), 0);

      // constrained random phase
      for (int n = 0; n < 6000; n++) begin
         if (n % 400 == 0) begin
            cfg_timeout_i = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom % 12 + 1);
            cfg_level_i   = 2'($urandom);
            ch_alarm_en_i = 8'($urandom);
            ch_action_i   = 16'($urandom);
         end
         tick_i        = ($urandom % 3) != 0;
         cmd_valid_i   = ($urandom % 6) == 0;
         cmd_refresh_i = ($urandom % 14) == 0;
         status_ack_i  = ($urandom % 10) == 0;
         step("R3");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule